// File: doc/BRIEF.md
# Big-Endian Scatter-Gather Descriptor Walker

This block follows a list of scatter-gather descriptors in memory and turns each one into an address/length segment for a downstream data mover. A start pulse hands the walker a list pointer. From that pointer the walker reads 16-byte descriptors one 32-bit word at a time, over a request/response memory port. It reverses the byte order of each word, because descriptors are stored most-significant byte first. It checks every descriptor and then presents one segment per descriptor on a valid/ready stream. The walk ends after the segment from the descriptor marked end-of-list has been taken.

A descriptor is four words. Word A is an upper address that must be zero. Word B is the 32-bit segment address. Word C is reserved and must be zero. Word D holds the flags and the length. The walker stops and reports an error code in four cases:

- a reserved word is nonzero;
- a length is zero;
- a segment would cross a 64 KiB address window;
- the list runs past its entry bound without an end-of-list entry.

A counter of the segments accepted in the current walk is available throughout.

Top module: `dlw_walker`

## Requirements
- R1: After reset the walker is idle: busy, rd_req_valid and seg_valid are low, entry_count is 0 and err_code is 0.
- R2: A start pulse while idle clears entry_count and err_code. It then requests the four words of the first descriptor at consecutive word addresses, beginning at list_ptr with its low four bits forced to zero. Each following descriptor is read 16 bytes after the previous one. A start pulse while busy has no effect on the walk.
- R3: A response word carries the byte at the requested address in bits 7:0 and the byte at address+3 in bits 31:24. Each descriptor word is the big-endian value of those four bytes, so the word is byte-reversed before it is used.
- R4: A segment carries seg_addr equal to word B and seg_last equal to bit 31 of word D. seg_len equals word D bits 15:0 when those bits are nonzero. When bits 15:0 are zero and bit 16 is set, seg_len is 65536. Bits 30:17 of word D are ignored, and so is bit 16 when the length is nonzero.
- R5: seg_valid and the segment fields stay stable until seg_ready is seen. Segments appear in list order. Once the end-of-list segment is accepted, busy drops on the next cycle.
- R6: When word A or word C of a descriptor is nonzero, the walk stops with err_code 1 and no segment for that descriptor.
- R7: When a descriptor has length bits 15:0 zero and bit 16 clear, the walk stops with err_code 2 and no segment.
- R8: When seg_len exceeds 65536 minus the low 16 bits of the address, the walk stops with err_code 3 and no segment. A segment that ends exactly on the window boundary is legal.
- R9: When MAX_ENTRIES segments have been accepted without an end-of-list flag, the walk stops with err_code 4 and no further reads.
- R10: entry_count rises by one for each accepted segment and holds its final value, together with err_code, until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken only while idle) |
| list_ptr | input | 32 | Byte address of the first descriptor |
| busy | output | 1 | A walk is in progress |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | 32 | Byte address of the requested word |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Walker accepts read data |
| rd_rsp_data | input | 32 | Read data, lowest-address byte in bits 7:0 |
| seg_valid | output | 1 | Segment valid |
| seg_ready | input | 1 | Data mover accepts the segment |
| seg_addr | output | 32 | Segment start address |
| seg_len | output | 17 | Segment length in bytes (1 to 65536) |
| seg_last | output | 1 | Segment comes from the end-of-list entry |
| entry_count | output | clog2(MAX_ENTRIES+1) | Segments accepted in this walk |
| err_code | output | 3 | 0 none, 1 reserved word, 2 zero length, 3 window crossing, 4 list overrun |

## Verification
The first read request is visible one cycle after start is sampled. Each response is consumed on the edge where it is valid. A segment is offered one cycle after the last word of its descriptor is consumed. An error code appears one cycle after the offending word, or after the bounding segment. busy falls one cycle after the final hand-off. The bench drives and samples on the falling edge, between rising edges. A scoreboard compares each segment on the falling edge just before the rising edge that takes it. The bench checks the request address on the falling edge that follows start. It reads err_code and entry_count only after busy has fallen.

// File: rtl/dlw_pkg.sv
package dlw_pkg;
    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int DESC_WORDS = 4;
    localparam int DESC_BYTES = DESC_WORDS * WORD_BYTES;
    localparam int WIN_BITS   = 16;
    localparam int LEN_W      = WIN_BITS + 1;
    localparam int EOL_BIT    = 31;
    localparam int FULL_BIT   = WIN_BITS;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_RSP,
        ST_SEG
    } walk_st_e;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_RSVD    = 3'd1,
        ERR_ZLEN    = 3'd2,
        ERR_CROSS   = 3'd3,
        ERR_OVERRUN = 3'd4
    } walk_err_e;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              last;
    } seg_t;
endpackage

// File: rtl/dlw_bswap.sv
module dlw_bswap #(
    parameter int BYTES = 4
) (
    input  logic [8*BYTES-1:0] din,
    output logic [8*BYTES-1:0] dout
);
    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        assign dout[8*i +: 8] = din[8*(BYTES-1-i) +: 8];
    end
endmodule

// File: rtl/dlw_len_decode.sv
module dlw_len_decode
    import dlw_pkg::*;
(
    input  logic [WIN_BITS-1:0] addr_lo,
    input  logic [WIN_BITS-1:0] len_fld,
    input  logic                full_flag,
    output logic [LEN_W-1:0]    seg_len,
    output logic                zero_err,
    output logic                cross_err
);
    logic [LEN_W-1:0] room;

    always_comb begin
        zero_err  = (len_fld == '0) && !full_flag;
        seg_len   = (len_fld == '0) ? {full_flag, {WIN_BITS{1'b0}}} : {1'b0, len_fld};
        room      = (LEN_W'(1) << WIN_BITS) - {1'b0, addr_lo};
        cross_err = seg_len > room;
    end
endmodule

// File: rtl/dlw_walker.sv
module dlw_walker
    import dlw_pkg::*;
#(
    parameter int MAX_ENTRIES = 64
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 start,
    input  logic [31:0]                          list_ptr,
    output logic                                 busy,
    output logic                                 rd_req_valid,
    input  logic                                 rd_req_ready,
    output logic [31:0]                          rd_req_addr,
    input  logic                                 rd_rsp_valid,
    output logic                                 rd_rsp_ready,
    input  logic [31:0]                          rd_rsp_data,
    output logic                                 seg_valid,
    input  logic                                 seg_ready,
    output logic [31:0]                          seg_addr,
    output logic [16:0]                          seg_len,
    output logic                                 seg_last,
    output logic [$clog2(MAX_ENTRIES+1)-1:0]     entry_count,
    output logic [2:0]                           err_code
);
    localparam int CNT_W   = $clog2(MAX_ENTRIES + 1);
    localparam int IDX_W   = $clog2(DESC_WORDS);
    localparam int ALIGN_W = $clog2(DESC_BYTES);
    localparam int BYTE_W  = $clog2(WORD_BYTES);

    walk_st_e          state;
    walk_err_e         err_q;
    logic [WORD_W-1:0] base_q;
    logic [IDX_W-1:0]  widx;
    logic [CNT_W-1:0]  cnt_q;
    seg_t              seg_q;

    logic [WORD_W-1:0] word_sw;
    logic [LEN_W-1:0]  dec_len;
    logic              dec_zero;
    logic              dec_cross;

    dlw_bswap #(.BYTES(WORD_BYTES)) u_swap (
        .din  (rd_rsp_data),
        .dout (word_sw)
    );

    dlw_len_decode u_dec (
        .addr_lo   (seg_q.addr[WIN_BITS-1:0]),
        .len_fld   (word_sw[WIN_BITS-1:0]),
        .full_flag (word_sw[FULL_BIT]),
        .seg_len   (dec_len),
        .zero_err  (dec_zero),
        .cross_err (dec_cross)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            err_q  <= ERR_NONE;
            base_q <= '0;
            widx   <= '0;
            cnt_q  <= '0;
            seg_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        base_q <= {list_ptr[WORD_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
                        widx   <= '0;
                        cnt_q  <= '0;
                        err_q  <= ERR_NONE;
                        state  <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (rd_req_ready) state <= ST_RSP;
                end
                ST_RSP: begin
                    if (rd_rsp_valid) begin
                        if (widx == IDX_W'(DESC_WORDS-1)) begin
                            if (dec_zero) begin
                                err_q <= ERR_ZLEN;
                                state <= ST_IDLE;
                            end else if (dec_cross) begin
                                err_q <= ERR_CROSS;
                                state <= ST_IDLE;
                            end else begin
                                seg_q.len  <= dec_len;
                                seg_q.last <= word_sw[EOL_BIT];
                                state      <= ST_SEG;
                            end
                        end else if (widx == IDX_W'(1)) begin
                            seg_q.addr <= word_sw;
                            widx       <= widx + IDX_W'(1);
                            state      <= ST_REQ;
                        end else if (word_sw != '0) begin
                            err_q <= ERR_RSVD;
                            state <= ST_IDLE;
                        end else begin
                            widx  <= widx + IDX_W'(1);
                            state <= ST_REQ;
                        end
                    end
                end
                ST_SEG: begin
                    if (seg_ready) begin
                        cnt_q <= cnt_q + CNT_W'(1);
                        if (seg_q.last) begin
                            state <= ST_IDLE;
                        end else if (cnt_q == CNT_W'(MAX_ENTRIES-1)) begin
                            err_q <= ERR_OVERRUN;
                            state <= ST_IDLE;
                        end else begin
                            base_q <= base_q + WORD_W'(DESC_BYTES);
                            widx   <= '0;
                            state  <= ST_REQ;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy         = (state != ST_IDLE);
    assign rd_req_valid = (state == ST_REQ);
    assign rd_req_addr  = base_q + {{(WORD_W-IDX_W-BYTE_W){1'b0}}, widx, {BYTE_W{1'b0}}};
    assign rd_rsp_ready = (state == ST_RSP);
    assign seg_valid    = (state == ST_SEG);
    assign seg_addr     = seg_q.addr;
    assign seg_len      = seg_q.len;
    assign seg_last     = seg_q.last;
    assign entry_count  = cnt_q;
    assign err_code     = err_q;
endmodule

// File: rtl/dlw_walker_chk.sv
module dlw_walker_chk #(
    parameter int MAX_ENTRIES = 64
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             start,
    input logic                             busy,
    input logic                             rd_req_valid,
    input logic                             rd_req_ready,
    input logic [31:0]                      rd_req_addr,
    input logic                             seg_valid,
    input logic                             seg_ready,
    input logic [31:0]                      seg_addr,
    input logic [16:0]                      seg_len,
    input logic                             seg_last,
    input logic [$clog2(MAX_ENTRIES+1)-1:0] entry_count,
    input logic [2:0]                       err_code
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!rd_req_valid && !seg_valid));

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

    // R2
    req_align_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> (rd_req_addr[1:0] == 2'b00));

    // R5
    seg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (seg_valid && !seg_ready) |=>
            (seg_valid && $stable(seg_addr) && $stable(seg_len) && $stable(seg_last)));

    // R5
    last_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (seg_valid && seg_ready && seg_last) |=> !busy);

    // R8
    no_cross_chk: assert property (@(posedge clk) disable iff (rst)
        seg_valid |-> ((seg_len != 17'd0) &&
                       (seg_len <= (17'h10000 - {1'b0, seg_addr[15:0]}))));

    // R9
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        entry_count <= ($clog2(MAX_ENTRIES+1))'(MAX_ENTRIES));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(err_code) && $stable(entry_count)));

    // R6
    err_no_seg_chk: assert property (@(posedge clk) disable iff (rst)
        (err_code != 3'd0) |-> !seg_valid);
endmodule

bind dlw_walker dlw_walker_chk #(.MAX_ENTRIES(MAX_ENTRIES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .busy         (busy),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .seg_valid    (seg_valid),
    .seg_ready    (seg_ready),
    .seg_addr     (seg_addr),
    .seg_len      (seg_len),
    .seg_last     (seg_last),
    .entry_count  (entry_count),
    .err_code     (err_code)
);

// File: tb/sim_dlw_walker.sv
`timescale 1ns/1ps
module sim_dlw_walker;
    localparam int MAXE = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] list_ptr = '0;
    logic        busy;
    logic        rd_req_valid;
    logic        rd_req_ready = 1'b1;
    logic [31:0] rd_req_addr;
    logic        rd_rsp_valid = 1'b0;
    logic        rd_rsp_ready;
    logic [31:0] rd_rsp_data = '0;
    logic        seg_valid;
    logic        seg_ready = 1'b0;
    logic [31:0] seg_addr;
    logic [16:0] seg_len;
    logic        seg_last;
    logic [6:0]  entry_count;
    logic [2:0]  err_code;

    int checks = 0;
    int fails  = 0;

    logic [31:0] mem [0:4095];
    logic [49:0] expq [$];

    always #2.5 clk = ~clk;

    dlw_walker #(.MAX_ENTRIES(MAXE)) u0 (
        .clk(clk), .rst(rst), .start(start), .list_ptr(list_ptr), .busy(busy),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
        .seg_last(seg_last), .entry_count(entry_count), .err_code(err_code)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] swap32(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [16:0] want_len(input logic [31:0] w3);
        if (w3[15:0] != 16'h0) return {1'b0, w3[15:0]};
        return w3[16] ? 17'h10000 : 17'h0;
    endfunction

    // driver side: store a big-endian descriptor and queue its expected segment
    task automatic put_entry(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1,
                             input logic [31:0] w2, input logic [31:0] w3, input bit expect_seg);
        mem[a[13:2]]          = swap32(w0);
        mem[a[13:2] + 12'd1]  = swap32(w1);
        mem[a[13:2] + 12'd2]  = swap32(w2);
        mem[a[13:2] + 12'd3]  = swap32(w3);
        if (expect_seg) expq.push_back({w1, want_len(w3), w3[31]});
    endtask

    // memory model: one response per request, latency alternating
    bit      pend = 0;
    int      pdelay = 0;
    bit      lat_tog = 0;
    logic [31:0] paddr = '0;
    int      cyc = 0;

    always @(negedge clk) begin
        cyc++;
        if (rd_rsp_valid) rd_rsp_valid = 1'b0;
        if (rd_req_valid && rd_req_ready) begin
            pend    = 1;
            paddr   = rd_req_addr;
            pdelay  = lat_tog ? 1 : 0;
            lat_tog = ~lat_tog;
        end else if (pend) begin
            if (pdelay > 0) pdelay--;
            else begin
                rd_rsp_valid = 1'b1;
                rd_rsp_data  = mem[paddr[13:2]];
                pend         = 0;
            end
        end
        // monitor: handshake will complete at the coming rising edge
        seg_ready = (cyc % 3) != 0;
        if (!rst && seg_valid && seg_ready) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R5 unexpected segment", {32'h0, seg_addr}, 64'h0);
            end else begin
                logic [49:0] e;
                e = expq.pop_front();
                chk(seg_addr == e[49:18], "R3/R4 seg_addr", {32'h0, seg_addr}, {32'h0, e[49:18]});
                chk(seg_len  == e[17:1],  "R4 seg_len", {47'h0, seg_len}, {47'h0, e[17:1]});
                chk(seg_last == e[0],     "R4 seg_last", {63'h0, seg_last}, {63'h0, e[0]});
            end
        end
    end

    task automatic run_list(input logic [31:0] ptr, input logic [2:0] e_err, input int e_cnt,
                            input string tag, input bit glitch);
        @(negedge clk);
        start = 1'b1; list_ptr = ptr;
        @(negedge clk);
        start = 1'b0;
        chk(rd_req_valid && rd_req_addr == {ptr[31:4], 4'h0}, "R2 first request address",
            {31'h0, rd_req_valid, rd_req_addr}, {32'h1, ptr[31:4], 4'h0});
        if (glitch) begin
            repeat (4) @(negedge clk);
            start = 1'b1; list_ptr = ptr ^ 32'h300;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        chk(expq.size() == 0, {tag, " all segments seen"}, 64'(expq.size()), 64'h0);
        chk(err_code == e_err, {tag, " err_code"}, {61'h0, err_code}, {61'h0, e_err});
        chk(int'(entry_count) == e_cnt, {tag, " entry_count"}, {57'h0, entry_count}, 64'(e_cnt));
        expq.delete();
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !rd_req_valid && !seg_valid, "R1 idle outputs",
            {61'h0, busy, rd_req_valid, seg_valid}, 64'h0);
        chk(entry_count == 0 && err_code == 0, "R1 count/err", {57'h0, entry_count}, 64'h0);

        // R3 R4 R5 R8: three entries, exact-boundary segment, full 64 KiB segment,
        // unaligned pointer, start pulse during the walk (R2)
        put_entry(32'h100, 32'h0, 32'h1234_5678, 32'h0, 32'h0000_0200, 1);
        put_entry(32'h110, 32'h0, 32'hA0B0_FF00, 32'h0, 32'h7FFE_0100, 1);
        put_entry(32'h120, 32'h0, 32'h3000_0000, 32'h0, 32'h8001_0000, 1);
        run_list(32'h0000_010B, 3'd0, 3, "R2/R5/R10 three-entry list", 1);

        // R4: single one-byte entry
        put_entry(32'hA00, 32'h0, 32'hDEAD_BEE0, 32'h0, 32'h8000_0001, 1);
        run_list(32'hA00, 3'd0, 1, "R4 single entry", 0);

        // R6: word A nonzero in second entry
        put_entry(32'h800, 32'h0, 32'h0001_0000, 32'h0, 32'h0000_0040, 1);
        put_entry(32'h810, 32'h1, 32'h0002_0000, 32'h0, 32'h8000_0040, 0);
        run_list(32'h800, 3'd1, 1, "R6 word A reserved", 0);

        // R6: word C nonzero
        put_entry(32'h900, 32'h0, 32'h0003_0000, 32'h0000_0100, 32'h8000_0040, 0);
        run_list(32'h900, 3'd1, 0, "R6 word C reserved", 0);

        // R7: zero length without the full flag
        put_entry(32'h600, 32'h0, 32'h0004_0000, 32'h0, 32'h8000_0000, 0);
        run_list(32'h600, 3'd2, 0, "R7 zero length", 0);

        // R8: crossing a 64 KiB window
        put_entry(32'h700, 32'h0, 32'h0000_FFF0, 32'h0, 32'h8000_0020, 0);
        run_list(32'h700, 3'd3, 0, "R8 window crossing", 0);

        // R9: list without end-of-list marker
        for (int k = 0; k < MAXE; k++)
            put_entry(32'h2000 + 32'(16 * k), 32'h0, 32'(k) << 16, 32'h0, 32'h0000_0100, 1);
        run_list(32'h2000, 3'd4, MAXE, "R9 overrun", 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule